// File: doc/BRIEF.md
# Exception and Interrupt Vector Controller

This block decides which trap event a 32-bit core services next. It covers three kinds of event. The first is a synchronous exception, raised by the core or by an illegal write to one of the block's own registers. The second is the non-maskable interrupt. The third is an external interrupt request carrying a 5-bit vector. The block holds three registers:

- the system-control register, with an interrupt-enable bit and a sticky trap bit;
- the vector-table base register;
- the return-pointer register.

When an event wins arbitration, the block fetches the 8-byte table entry for it and checks the entry's present flag. If the entry is usable, the block issues a one-cycle redirect to the handler address. When the block accepts an event, it records the return address.

The trap bit marks that an exception is being handled. While the trap bit is set, external requests are held off. A further exception in that state is not vectored. Instead the block raises a one-cycle reset request, clears its registers, and then redirects the core to the boot address. The same boot redirect is issued in the first cycle after reset is released.

Requests are sampled only while the block is idle, meaning it is neither fetching an entry nor booting. A register write offered in the same idle cycle as an accepted event is dropped.

Top module: `exc_vector_ctrl`

## Requirements
- R1: During reset, the system-control, table-base and return-pointer outputs read zero, and neither redirect nor reset request is asserted. In the first cycle after reset is released, a redirect to RESET_PC (default 0x0000FF00) is issued.
- R2: The entry address is `tbl_base_q + 8*entry`. `tbl_base_q` keeps bits 31:3, and bits 2:0 of it are always zero. `tbl_rd` is held high until `tbl_valid` arrives. Exception number n uses entry n (0..15).
- R3: A table word with bit 0 = 1 and bit 1 = 0 is a present entry. For a present entry, the next cycle brings a one-cycle `redir` with `redir_pc = {word[31:2], 2'b00}`. No redirect is issued while `tbl_valid` is low.
- R4: An IRQ with vector v uses entry 32+v. It is accepted only when the interrupt-enable bit (system-control bit 0) is 1 and the trap bit (bit 31) is 0.
- R5: The NMI uses entry 7 and is accepted regardless of the interrupt-enable bit and the trap bit.
- R6: Among events sampled in the same idle cycle, the priority order is: `exc_req` first, then a faulting register write, then the NMI, then the IRQ.
- R7: Accepting an exception sets the trap bit. The NMI and IRQs leave it unchanged. The trap bit falls only on a software write or on an escalation.
- R8: An exception accepted while the trap bit is 1 pulses `rst_req` for one cycle and clears the system-control and table-base registers. A redirect to RESET_PC follows in the next cycle.
- R9: On acceptance, the return pointer takes `cur_ip` for an exception and `next_ip` for the NMI or an IRQ.
- R10: Register select 0 is system control, 1 is table base, 2 is return pointer and 3 is undefined. Each bad write raises an exception at the entry given here and leaves the target register unchanged:
  - a system-control write with any of bits 30:1 set raises entry 4;
  - a table-base write with any of bits 2:0 set raises entry 4;
  - any write to select 3 raises entry 2.
- R11: If an entry is not present and the accepted event was the NMI or an IRQ, the block sets the trap bit and fetches entry 2. If the event was an exception, the block escalates as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request from the core |
| exc_num | input | 4 | Exception number (table entry 0..15) |
| nmi | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | External interrupt request |
| irq_vec | input | 5 | IRQ vector, selects entry 32+vec |
| cur_ip | input | 32 | Address of the current (faulting) instruction |
| next_ip | input | 32 | Address of the next instruction or taken-branch target |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| tbl_rd | output | 1 | Table entry fetch request |
| tbl_addr | output | 32 | Table entry address |
| tbl_valid | input | 1 | Fetched table word is valid |
| tbl_data | input | 32 | First word of the fetched table entry |
| redir | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | Redirect target |
| rst_req | output | 1 | One-cycle processor reset request |
| sysctl_q | output | 32 | System-control register |
| tbl_base_q | output | 32 | Table-base register |
| ret_ptr_q | output | 32 | Return-pointer register |

## Verification
The bench aims at the following corner cases:

- **Escalation paths.** These are an exception taken with the trap bit already set, and an exception whose own entry is absent. A design that vectored either case would branch into a handler instead of pulsing `rst_req` and rebooting.
- **Simultaneous events.** The bench offers an exception, the NMI and an IRQ in the same cycle, and an IRQ while the trap bit is set. A wrong priority order or a missing mask would show up as the wrong entry address on `tbl_addr`.
- **Illegal register writes.** The bench writes to reserved system-control bits, writes a misaligned table base, and writes to the undefined select. A design that stored these values, or did not fault, would show an unchanged `tbl_rd` and a corrupted register output.
- **Absent IRQ entry and a stalled table fetch.** These catch a design that redirects to an unusable entry, or that redirects before the table word arrives.

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl #(
  parameter logic [31:0] RESET_PC = 32'h0000_FF00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req,
  input  logic [3:0]  exc_num,
  input  logic        nmi,
  input  logic        irq_req,
  input  logic [4:0]  irq_vec,
  input  logic [31:0] cur_ip,
  input  logic [31:0] next_ip,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        tbl_rd,
  output logic [31:0] tbl_addr,
  input  logic        tbl_valid,
  input  logic [31:0] tbl_data,
  output logic        redir,
  output logic [31:0] redir_pc,
  output logic        rst_req,
  output logic [31:0] sysctl_q,
  output logic [31:0] tbl_base_q,
  output logic [31:0] ret_ptr_q
);
  localparam int ENT_W = 6;
  localparam logic [ENT_W-1:0] NMI_ENT   = 6'd7;
  localparam logic [ENT_W-1:0] BADOP_ENT = 6'd2;
  localparam logic [ENT_W-1:0] CONS_ENT  = 6'd4;
  localparam logic [ENT_W-1:0] IRQ_BASE  = 6'd32;

  typedef enum logic [1:0] {S_BOOT, S_IDLE, S_FETCH} st_t;
  st_t st;

  logic        ie, trap, in_exc;
  logic [28:0] base;
  logic [31:0] ret;

  logic             wr_bad;
  logic [ENT_W-1:0] wr_ent;
  logic             take_exc, take_irq, any_evt;
  logic [ENT_W-1:0] exc_ent, ent;
  logic             present;

  assign sysctl_q   = {trap, 30'b0, ie};
  assign tbl_base_q = {base, 3'b000};
  assign ret_ptr_q  = ret;
  assign tbl_rd     = (st == S_FETCH);
  assign present    = tbl_data[0] & ~tbl_data[1];

  always_comb begin
    wr_bad = 1'b0;
    wr_ent = CONS_ENT;
    if (reg_wr) begin
      case (reg_sel)
        2'd0:    wr_bad = |reg_wdata[30:1];
        2'd1:    wr_bad = |reg_wdata[2:0];
        2'd2:    wr_bad = 1'b0;
        default: begin wr_bad = 1'b1; wr_ent = BADOP_ENT; end
      endcase
    end
  end

  assign take_exc = exc_req | wr_bad;
  assign exc_ent  = exc_req ? {2'b00, exc_num} : wr_ent;
  assign take_irq = irq_req & ie & ~trap;
  assign any_evt  = take_exc | nmi | take_irq;
  assign ent      = take_exc ? exc_ent : (nmi ? NMI_ENT : IRQ_BASE + {1'b0, irq_vec});

  function automatic logic [31:0] ent_addr(input logic [ENT_W-1:0] e);
    return {base + {23'b0, e}, 3'b000};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_BOOT;
      ie <= 1'b0;
      trap <= 1'b0;
      in_exc <= 1'b0;
      base <= '0;
      ret <= '0;
      tbl_addr <= '0;
      redir <= 1'b0;
      redir_pc <= '0;
      rst_req <= 1'b0;
    end else begin
      redir <= 1'b0;
      rst_req <= 1'b0;
      case (st)
        S_BOOT: begin
          redir <= 1'b1;
          redir_pc <= RESET_PC;
          st <= S_IDLE;
        end
        S_IDLE: begin
          if (take_exc && trap) begin
            rst_req <= 1'b1;
            ie <= 1'b0;
            trap <= 1'b0;
            base <= '0;
            st <= S_BOOT;
          end else if (any_evt) begin
            tbl_addr <= ent_addr(ent);
            ret <= take_exc ? cur_ip : next_ip;
            in_exc <= take_exc;
            if (take_exc) trap <= 1'b1;
            st <= S_FETCH;
          end else if (reg_wr) begin
            case (reg_sel)
              2'd0:    begin trap <= reg_wdata[31]; ie <= reg_wdata[0]; end
              2'd1:    base <= reg_wdata[31:3];
              default: ret <= reg_wdata;
            endcase
          end
        end
        S_FETCH: begin
          if (tbl_valid) begin
            if (present) begin
              redir <= 1'b1;
              redir_pc <= {tbl_data[31:2], 2'b00};
              st <= S_IDLE;
            end else if (in_exc) begin
              rst_req <= 1'b1;
              ie <= 1'b0;
              trap <= 1'b0;
              base <= '0;
              st <= S_BOOT;
            end else begin
              tbl_addr <= ent_addr(BADOP_ENT);
              in_exc <= 1'b1;
              trap <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_FF00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_sel,
  input logic        tbl_rd,
  input logic [31:0] tbl_addr,
  input logic        redir,
  input logic [31:0] redir_pc,
  input logic        rst_req,
  input logic [31:0] sysctl_q,
  input logic [31:0] tbl_base_q
);
  logic [31:0] off;
  assign off = tbl_addr - tbl_base_q;

  // R2
  entry_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |-> (off[2:0] == 3'b000 && off < 32'd512));

  // R4
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tbl_rd) && off >= 32'd256) |-> $past(sysctl_q[0] && !sysctl_q[31]));

  // R7
  exc_sets_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tbl_rd) && off < 32'd128 && off != 32'd56) |-> sysctl_q[31]);

  // R7
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysctl_q[31]) |-> (rst_req || $past(reg_wr && reg_sel == 2'd0)));

  // R8
  escalate_in_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(sysctl_q[31]));

  // R8
  reboot_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (redir && redir_pc == RESET_PC));

  // R3
  single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redir, rst_req, tbl_rd && redir}));
endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk #(.RESET_PC(RESET_PC)) u_chk (.*);

// File: tb/exc_vector_ctrl_tb.sv
module exc_vector_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] BOOT = 32'h0000_FF00;
  localparam logic [31:0] CIP = 32'h0000_1234;
  localparam logic [31:0] NIP = 32'h0000_1238;

  logic clk = 0, rst_n = 0;
  logic exc_req = 0, nmi = 0, irq_req = 0, reg_wr = 0, stall = 0;
  logic [3:0] exc_num = 0;
  logic [4:0] irq_vec = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] cur_ip = CIP, next_ip = NIP;
  logic tbl_rd, tbl_valid, redir, rst_req;
  logic [31:0] tbl_addr, tbl_data, redir_pc, sysctl_q, tbl_base_q, ret_ptr_q;
  logic [31:0] mem [0:1023];

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  assign tbl_valid = tbl_rd & ~stall;
  assign tbl_data  = mem[tbl_addr[12:3]];

  exc_vector_ctrl u_dut (.*);

  function automatic logic [31:0] hnd(input int i);
    return 32'h1000_0000 | (i << 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int  m_st = 0;
  bit  m_live = 0, m_ie = 0, m_trap = 0, m_inexc = 0, m_redir = 0, m_rst = 0, m_isx;
  int  m_e;
  logic [31:0] m_base = 0, m_ret = 0, m_pc = 0, m_addr = 0, m_word;

  task automatic m_escalate();
    m_rst = 1; m_ie = 0; m_trap = 0; m_base = 0; m_st = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ie = 0; m_trap = 0; m_base = 0; m_ret = 0;
      m_redir = 0; m_rst = 0; m_live = 1;
    end else begin
      m_redir = 0; m_rst = 0;
      if (m_st == 0) begin
        m_redir = 1; m_pc = BOOT; m_st = 1;
      end else if (m_st == 1) begin
        m_e = -1; m_isx = 0;
        if (exc_req) begin m_e = int'(exc_num); m_isx = 1; end
        else if (reg_wr && reg_sel == 3) begin m_e = 2; m_isx = 1; end
        else if (reg_wr && reg_sel == 0 && (reg_wdata & 32'h7FFF_FFFE) != 0) begin m_e = 4; m_isx = 1; end
        else if (reg_wr && reg_sel == 1 && reg_wdata[2:0] != 0) begin m_e = 4; m_isx = 1; end
        else if (nmi) m_e = 7;
        else if (irq_req && m_ie && !m_trap) m_e = 32 + int'(irq_vec);
        if (m_e >= 0) begin
          if (m_isx && m_trap) m_escalate();
          else begin
            m_addr = m_base + m_e * 8;
            m_ret = m_isx ? cur_ip : next_ip;
            m_inexc = m_isx;
            if (m_isx) m_trap = 1;
            m_st = 2;
          end
        end else if (reg_wr) begin
          if (reg_sel == 0) begin m_trap = reg_wdata[31]; m_ie = reg_wdata[0]; end
          else if (reg_sel == 1) m_base = reg_wdata;
          else m_ret = reg_wdata;
        end
      end else if (!stall) begin
        m_word = mem[m_addr[12:3]];
        if (m_word[1:0] == 2'b01) begin
          m_redir = 1; m_pc = m_word & 32'hFFFF_FFFC; m_st = 1;
        end else if (m_inexc) m_escalate();
        else begin
          m_addr = m_base + 16; m_inexc = 1; m_trap = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (m_live && rst_n) begin
      chk("R3 redir", {31'b0, redir}, {31'b0, m_redir});
      if (m_redir) chk("R3 redir_pc", redir_pc, m_pc);
      chk("R8 rst_req", {31'b0, rst_req}, {31'b0, m_rst});
      chk("R2 tbl_rd", {31'b0, tbl_rd}, {31'b0, m_st == 2});
      if (m_st == 2) chk("R2 tbl_addr", tbl_addr, m_addr);
      chk("R7 sysctl", sysctl_q, {m_trap, 30'b0, m_ie});
      chk("R10 base", tbl_base_q, m_base);
      chk("R9 ret", ret_ptr_q, m_ret);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic fire(input bit e, input logic [3:0] n, input bit nm, input bit iq, input logic [4:0] v);
    exc_req = e; exc_num = n; nmi = nm; irq_req = iq; irq_vec = v;
    @(negedge clk);
    exc_req = 0; nmi = 0; irq_req = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = hnd(i) | 32'h1;
    mem[40] = hnd(40);
    mem[5]  = 32'h0000_0000;
    repeat (2) @(negedge clk);
    // r1_ reset state
    chk("R1 sysctl", sysctl_q, 0);
    chk("R1 base", tbl_base_q, 0);
    chk("R1 ret", ret_ptr_q, 0);
    chk("R1 redir", {31'b0, redir}, 0);
    chk("R1 rst_req", {31'b0, rst_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 boot redir", {31'b0, redir}, 1);
    chk("R1 boot pc", redir_pc, BOOT);
    @(negedge clk);

    // R4 masked
    fire(0, 0, 0, 1, 5'd3);
    chk("R4 irq masked", {31'b0, tbl_rd}, 0);
    settle();
    wr(2'd0, 32'h1);
    fire(0, 0, 0, 1, 5'd3);
    chk("R4 irq entry", tbl_addr, 32'h118);
    @(negedge clk);
    chk("R3 handler", redir_pc, hnd(35));
    chk("R9 irq ret", ret_ptr_q, NIP);
    chk("R7 irq keeps trap", sysctl_q, 32'h1);
    settle();

    // R5 R6
    wr(2'd1, 32'h400);
    fire(0, 0, 1, 1, 5'd3);
    chk("R6 nmi over irq", tbl_addr, 32'h438);
    settle();
    wr(2'd0, 32'h0);
    fire(0, 0, 1, 0, 0);
    chk("R5 nmi ignores ie", tbl_addr, 32'h438);
    settle();
    fire(1, 4'd9, 1, 0, 0);
    chk("R6 exc over nmi", tbl_addr, 32'h448);
    chk("R9 exc ret", ret_ptr_q, CIP);
    chk("R7 trap set", sysctl_q, 32'h8000_0000);
    settle();

    // R4 blocked by trap, R5 nmi passes in trap
    wr(2'd0, 32'h8000_0001);
    fire(0, 0, 0, 1, 5'd1);
    chk("R4 irq blocked by trap", {31'b0, tbl_rd}, 0);
    settle();
    fire(0, 0, 1, 0, 0);
    chk("R5 nmi in trap", tbl_addr, 32'h438);
    settle();
    chk("R7 nmi keeps trap", sysctl_q, 32'h8000_0001);

    // R8 escalation
    fire(1, 4'd3, 0, 0, 0);
    chk("R8 rst_req", {31'b0, rst_req}, 1);
    chk("R8 sysctl cleared", sysctl_q, 0);
    chk("R8 base cleared", tbl_base_q, 0);
    @(negedge clk);
    chk("R8 reboot", redir_pc, BOOT);
    settle();

    // R10 bad writes
    wr(2'd0, 32'h2);
    chk("R10 sysctl fault entry", tbl_addr, 32'h20);
    chk("R10 sysctl not written", sysctl_q, 32'h8000_0000);
    settle();
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h404);
    chk("R10 base fault entry", tbl_addr, 32'h20);
    chk("R10 base unchanged", tbl_base_q, 0);
    settle();
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    chk("R10 undefined select", tbl_addr, 32'h10);
    settle();

    // R11 absent irq entry
    wr(2'd0, 32'h1);
    fire(0, 0, 0, 1, 5'd8);
    chk("R11 irq fetch", tbl_addr, 32'h140);
    @(negedge clk);
    chk("R11 fallback entry", tbl_addr, 32'h10);
    chk("R11 trap set", sysctl_q, 32'h8000_0001);
    @(negedge clk);
    chk("R11 fallback handler", redir_pc, hnd(2));
    settle();

    // R11 absent exception entry
    wr(2'd0, 32'h0);
    fire(1, 4'd5, 0, 0, 0);
    @(negedge clk);
    chk("R11 absent exc escalates", {31'b0, rst_req}, 1);
    @(negedge clk);
    chk("R11 reboot", redir_pc, BOOT);
    settle();

    // R3 stalled fetch
    wr(2'd0, 32'h1);
    stall = 1;
    fire(0, 0, 0, 1, 5'd0);
    repeat (2) @(negedge clk);
    chk("R3 no redirect while stalled", {31'b0, redir}, 0);
    stall = 0;
    @(negedge clk);
    chk("R3 redirect after stall", redir_pc, hnd(32));
    settle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule